// File: doc/BRIEF.md
# Serial result output stage for a conversion device

This block is the device-side end of a chip-select gated serial read port. A result source hands it a 22-bit word (sign plus a 21-bit magnitude field) with a one-cycle done strobe. The block holds that word until a host reads it. The host selects the device with an active-low chip select and supplies a serial clock. The block turns this into a 24-bit frame on a data line, and a separate enable says when that line should be driven.

The first frame bit is a live ready flag, shown as soon as the device is selected and before any clock. It is low when an unread result is waiting and high while a conversion is still running. The remaining bits leave on falling serial-clock edges, most significant first. On the 24th falling edge the line returns to the ready flag of the next cycle, which reads high (busy) until a new result lands. The block also issues a one-cycle conversion-start pulse at that point.

Chip select and the serial clock are brought into the system clock domain through two-flop synchronizers, and all edge detection happens there. The serial clock must therefore run at no more than a quarter of the system clock.

Top module: `adc_frame_tx`

## Requirements
- R1: While chip select is high, sdo_oe is low, sdo is 0, and serial clock pulses have no effect on the frame or on the bit counter.
- R2: With chip select low and before the first falling clock, sdo shows the inverted ready flag. It is 0 when an unread result is held and 1 when none is held, and it tracks a result that arrives while selected.
- R3: Each falling serial-clock edge of a frame presents the next bit. Bit 22 appears after the 1st falling edge and bit 0 after the 23rd.
- R4: Frame layout, from bit 23 down to bit 0: the ready flag (0 = result ready), a constant 0, then the 22-bit result word with its bit 21 (sign) first.
- R5: After the 24th falling edge, sdo shows the inverted ready flag again. It reads 1 if no new result arrived during the frame.
- R6: If chip select rises before the 24th falling edge, the frame is abandoned. The result stays held and ready, and the next full read returns the same word.
- R7: A result arriving in the middle of a frame does not alter the frame being shifted. It stays held and ready for the next read.
- R8: conv_start pulses high for exactly one system clock per completed frame, on the 24th falling edge, and at no other time.
- R9: Falling edges after the 24th are ignored until chip select goes high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_word | input | 22 | Result word: sign in bit 21, magnitude field below it |
| res_valid | input | 1 | One-cycle strobe: res_word holds a finished conversion |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, at most a quarter of clk |
| sdo | output | 1 | Serial data out, 0 while disabled |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| conv_start | output | 1 | One-cycle pulse asking the source to start the next conversion |

## Verification
The bench sweeps a walking one across all 22 result bits, plus all-zero, all-one and alternating words. It compares every frame bit with the expected layout, which catches an off-by-one in the shift or the first bit being shifted too early. It clocks the port heavily while deselected and then reads a clean frame; a design that counted those clocks would return a shifted frame. It abandons frames midway and injects a new result during a frame. A design that cleared ready on abandon would show busy on the next select, and one that reloaded mid-frame would return a mixed word. It also sends extra clocks after the 24th and counts conv_start pulses, which exposes a counter that wraps into a second frame.

// File: rtl/adc_frame_tx.sv
module adc_frame_tx #(
  parameter int RES_W = 21,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W:0]   res_word,
  input  logic             res_valid,
  input  logic             cs_n,
  input  logic             sclk,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             conv_start
);
  localparam int FRAME = RES_W + 3;
  localparam int CW    = $clog2(FRAME + 1);

  logic [SYNC-1:0]  cs_sync, sck_sync;
  logic             sck_prev;
  logic [RES_W:0]   hold;
  logic             ready, fresh;
  logic [FRAME-2:0] sh;
  logic [CW-1:0]    cnt;

  wire cs_act = ~cs_sync[SYNC-1];
  wire fall   = cs_act & sck_prev & ~sck_sync[SYNC-1];
  wire at_end = (cnt == CW'(FRAME));
  wire at_top = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= '1;
      sck_sync <= '0;
      sck_prev <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[SYNC-2:0], cs_n};
      sck_sync <= {sck_sync[SYNC-2:0], sclk};
      sck_prev <= sck_sync[SYNC-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= '0;
      ready      <= 1'b0;
      fresh      <= 1'b0;
      sh         <= '0;
      cnt        <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (at_top) sh <= {1'b0, hold};
      if (!cs_act) begin
        cnt   <= '0;
        fresh <= 1'b0;
      end else if (fall && !at_end) begin
        cnt <= cnt + 1'b1;
        if (!at_top) sh <= {sh[FRAME-3:0], 1'b0};
        if (cnt == CW'(FRAME - 1)) begin
          conv_start <= 1'b1;
          if (!fresh) ready <= 1'b0;
        end
      end
      if (res_valid) begin
        hold  <= res_word;
        ready <= 1'b1;
        if (!at_top) fresh <= 1'b1;
      end
    end
  end

  wire bit_now = (at_top || at_end) ? ~ready : sh[FRAME-2];

  assign sdo    = cs_act & bit_now;
  assign sdo_oe = cs_act;
endmodule

module adc_frame_tx_chk #(
  parameter int RES_W = 21,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          res_valid,
  input logic          sdo_oe,
  input logic          conv_start,
  input logic          ready,
  input logic [CW-1:0] cnt
);
  localparam int FRAME = RES_W + 3;

  a_r1_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> !sdo_oe);

  a_r2_result_marks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r8_pulse_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (cnt == CW'(FRAME)));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME));
endmodule

bind adc_frame_tx adc_frame_tx_chk #(.RES_W(RES_W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .res_valid(res_valid),
  .sdo_oe(sdo_oe), .conv_start(conv_start), .ready(ready), .cnt(cnt)
);

// File: tb/adc_frame_tx_tb.sv
module adc_frame_tx_tb_top;
  localparam int RES_W = 21;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RES_W:0] res_word = '0;
  logic res_valid = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic sdo, sdo_oe, conv_start;

  int n_chk = 0, n_bad = 0, pulses = 0;
  logic done = 1'b0;

  adc_frame_tx #(.RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .res_word(res_word), .res_valid(res_valid),
    .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start)
  );

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n && conv_start) pulses <= pulses + 1;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sck();
    sclk = 1'b1; wait_n(HALF);
    sclk = 1'b0; wait_n(HALF);
  endtask

  task automatic give(input logic [RES_W:0] w);
    @(negedge clk); res_word = w; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
    wait_n(2);
  endtask

  task automatic select(); cs_n = 1'b0; wait_n(HALF); endtask
  task automatic deselect(); cs_n = 1'b1; wait_n(HALF); endtask

  task automatic read_frame(input logic [RES_W:0] w, input string tag);
    logic [23:0] exp;
    int p0;
    exp = {1'b0, 1'b0, w};
    p0 = pulses;
    select();
    chk(sdo, 1'b0, {tag, " R2 ready flag"});
    for (int i = 22; i >= 0; i--) begin
      pulse_sck();
      chk(sdo, exp[i], $sformatf("%s R3 R4 bit %0d", tag, i));
    end
    pulse_sck();
    chk(sdo, 1'b1, {tag, " R5 busy after 24th"});
    chk(pulses - p0, 1, {tag, " R8 one start pulse"});
    deselect();
  endtask

  initial begin
    #400000;
    $display("FAIL watchdog expired");
    n_chk++; n_bad++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [RES_W:0] a, b;
    int p0;
    wait_n(3); rst_n = 1'b1; wait_n(3);
    chk(sdo_oe, 1'b0, "R1 reset oe");
    chk(sdo, 1'b0, "R1 reset sdo");
    chk(conv_start, 1'b0, "R8 reset pulse");

    select();
    chk(sdo_oe, 1'b1, "R2 oe when selected");
    chk(sdo, 1'b1, "R2 busy before result");
    give(22'h12345);
    wait_n(2);
    chk(sdo, 1'b0, "R2 live ready while selected");
    deselect();
    read_frame(22'h12345, "first");

    for (int k = 0; k < 26; k++) begin
      if (k < 22) a = 22'(1) << k;
      else if (k == 22) a = '0;
      else if (k == 23) a = '1;
      else if (k == 24) a = 22'h2AAAAA;
      else a = 22'h155555;
      give(a);
      read_frame(a, $sformatf("sweep%0d", k));
    end

    give(22'h3C0F0A);
    p0 = pulses;
    for (int i = 0; i < 30; i++) pulse_sck();
    chk(sdo_oe, 1'b0, "R1 oe low with clocks deselected");
    chk(sdo, 1'b0, "R1 sdo low deselected");
    chk(pulses - p0, 0, "R1 no pulse while deselected");
    read_frame(22'h3C0F0A, "R1 after ignored clocks");

    give(22'h0ABCDE);
    p0 = pulses;
    select();
    for (int i = 0; i < 10; i++) pulse_sck();
    deselect();
    select();
    chk(sdo, 1'b0, "R6 still ready after abandon");
    deselect();
    chk(pulses - p0, 0, "R6 no pulse on abandon");
    read_frame(22'h0ABCDE, "R6 reread");

    a = 22'h2F00F1; b = 22'h05A5A5;
    give(a);
    select();
    for (int i = 22; i >= 0; i--) begin
      pulse_sck();
      if (i == 17) give(b);
      chk(sdo, ({2'b00, a} >> i) & 1, $sformatf("R7 frame bit %0d", i));
    end
    pulse_sck();
    chk(sdo, 1'b0, "R7 new result still ready after frame");
    p0 = pulses;
    for (int i = 0; i < 3; i++) pulse_sck();
    chk(sdo, 1'b0, "R9 extra clocks leave ready flag");
    chk(pulses - p0, 0, "R9 no extra pulse");
    deselect();
    read_frame(b, "R7 next read");

    select();
    for (int i = 0; i < 24; i++) pulse_sck();
    for (int i = 0; i < 5; i++) pulse_sck();
    chk(sdo, 1'b1, "R9 R5 busy held after extra clocks");
    give(22'h111111);
    wait_n(2);
    chk(sdo, 1'b0, "R5 flag tracks new result live");
    deselect();
    read_frame(22'h111111, "final");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule